// File: doc/BRIEF.md
# I2S Sample-Rate Switch Controller

This block sits beside an I2S receive buffer. It measures the word-clock (LRCLK) period of the incoming stream against a local reference clock and classifies it as one of six audio sample rates. When a new rate becomes stable, the block mutes the output and holds the buffer empty. It then pulls an active-low interrupt line to wake an external clock-master controller and publishes the rate code, the oscillator family and the MCLK multiple that controller needs.

The block is a slave. It never applies a clock itself. It waits for the controller to acknowledge, lets the new clock settle for a set number of measurement windows, and confirms that the measured rate still matches the requested one. Only then does it unmute and show a steady lock indication. If the controller stays silent, the block asks once more and then raises an error flag.

Top module: `i2s_rate_switch`

## Requirements
- R1: A measurement counts reference cycles over WIN_PERIODS rising LRCLK edges. The count is compared with six windows of ±2% around the nominal count. `rateCode` reports the requested rate as 1=44.1, 2=48, 3=88.2, 4=96, 5=176.4, 6=192 kHz, and 0 means no rate. A count outside every window, or an LRCLK that stops, yields 0.
- R2: `famSel` is 0 for the 44.1/88.2/176.4 kHz family (22.5792 MHz oscillator) and 1 for the 48/96/192 kHz family (24.576 MHz oscillator).
- R3: `mclkMult` encodes the MCLK multiple as 2=512·Fs for 44.1/48 kHz, 1=256·Fs for 88.2/96 kHz, and 0=128·Fs for 176.4/192 kHz.
- R4: A rate is acted on only after QUAL_COUNT (3) consecutive measurements give the same code. A disturbance of one or two windows while locked changes no output.
- R5: When a qualified valid rate differs from the one in use, `irqN` goes low. In the same cycle `muteOut` and `fifoEmptyOut` are high and `rateCode` shows the new rate.
- R6: While a switch is pending (interrupt outstanding, retry gap, settling or error), `lockLed` toggles and `fifoEmptyOut` stays high.
- R7: A rising edge on `ackIn` releases `irqN`. After SETTLE_WIN further windows, a matching measurement gives steady `lockLed`=1, `muteOut`=0 and `fifoEmptyOut`=0. A mismatch drops the request and qualification starts again.
- R8: If no acknowledge arrives within ACK_TIMEOUT cycles, `irqN` is released for RETRY_GAP cycles and then asserted again. A second timeout sets `errorOut`, keeps `irqN` high and keeps the output muted. A later qualified rate change clears the error and issues a new request.
- R9: A qualified "no rate" result while locked mutes the output, clears `lockLed` and `rateCode`, and asserts no interrupt.
- R10: After reset the block is muted and unlocked, with `rateCode`=0, `irqN`=1 and `errorOut`=0. The first qualified valid rate is handled as a rate change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all measurement and control |
| rstN | input | 1 | Asynchronous active-low reset |
| lrclkIn | input | 1 | Incoming I2S word clock, asynchronous |
| ackIn | input | 1 | Acknowledge from the clock controller, asynchronous |
| irqN | output | 1 | Active-low wake-up request to the clock controller |
| muteOut | output | 1 | Silences the I2S output when high |
| fifoEmptyOut | output | 1 | Forces the receive buffer empty when high |
| lockLed | output | 1 | Steady high when locked, toggling while a switch is pending |
| errorOut | output | 1 | Controller failed to acknowledge twice |
| rateCode | output | 3 | Requested sample-rate code |
| famSel | output | 1 | Oscillator family select |
| mclkMult | output | 2 | MCLK multiple code |

## Verification
The bench drives clean square waves at each of the six rates. This separates the windows and shows that the family and multiple decode is right for every code. An LRCLK with one narrow extra pulse tells a real rate change apart from a disturbed window. A period that falls between all windows checks the no-rate path without an interrupt. A controller that never answers exercises the single retry and the error flag. Changing the rate during the settle phase shows that the final re-check refuses a rate that no longer matches.

// File: rtl/rate_det_pkg.sv
package rate_det_pkg;

  localparam int NUM_RATES = 6;
  localparam int CODE_W    = 3;

  typedef struct packed {
    logic restartMeas;
    logic loadReq;
    logic clrReq;
  } ctrlStrb_t;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_REQ,
    ST_GAP,
    ST_SETTLE,
    ST_LOCK,
    ST_ERR
  } seqState_t;

  // sample rate in units of 100 Hz, index 0..5 maps to codes 1..6
  function automatic int rateHecto(input int idx);
    case (idx)
      0:       return 441;
      1:       return 480;
      2:       return 882;
      3:       return 960;
      4:       return 1764;
      default: return 1920;
    endcase
  endfunction

  function automatic int nominalCount(input int refKhz, input int winPeriods, input int idx);
    return (refKhz * 10 * winPeriods) / rateHecto(idx);
  endfunction

  function automatic int windowLow(input int refKhz, input int winPeriods, input int idx);
    int n;
    n = nominalCount(refKhz, winPeriods, idx);
    return n - n / 50;
  endfunction

  function automatic int windowHigh(input int refKhz, input int winPeriods, input int idx);
    int n;
    n = nominalCount(refKhz, winPeriods, idx);
    return n + n / 50;
  endfunction

endpackage

// File: rtl/rate_meas_path.sv
module rate_meas_path
  import rate_det_pkg::*;
#(
  parameter int REF_KHZ     = 24576,
  parameter int WIN_PERIODS = 64,
  parameter int FLASH_W     = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lrclkIn,
  input  logic              ackIn,
  input  ctrlStrb_t         strb,
  output logic              measDone,
  output logic [CODE_W-1:0] measCode,
  output logic [CODE_W-1:0] reqCode,
  output logic              ackRise,
  output logic              flashBit,
  output logic              famSel,
  output logic [1:0]        mclkMult
);

  // slowest rate has the largest count
  localparam int MAX_HI = windowHigh(REF_KHZ, WIN_PERIODS, 0);
  localparam int CNT_W  = $clog2(MAX_HI + 2);
  localparam int PER_W  = (WIN_PERIODS > 1) ? $clog2(WIN_PERIODS) : 1;

  logic [2:0] lrSync;
  logic [2:0] ackSync;
  logic       lrRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lrSync  <= '0;
      ackSync <= '0;
    end else begin
      lrSync  <= {lrSync[1:0], lrclkIn};
      ackSync <= {ackSync[1:0], ackIn};
    end
  end

  assign lrRise  = lrSync[1] & ~lrSync[2];
  assign ackRise = ackSync[1] & ~ackSync[2];

  logic [CNT_W-1:0]     refCnt;
  logic [CNT_W-1:0]     elapsed;
  logic [PER_W-1:0]     perCnt;
  logic                 armed;
  logic [NUM_RATES-1:0] inWin;
  logic [CODE_W-1:0]    winCode;

  assign elapsed = refCnt + 1'b1;

  generate
    for (genvar gi = 0; gi < NUM_RATES; gi++) begin : g_win
      localparam int LO = windowLow(REF_KHZ, WIN_PERIODS, gi);
      localparam int HI = windowHigh(REF_KHZ, WIN_PERIODS, gi);
      assign inWin[gi] = (elapsed >= CNT_W'(LO)) && (elapsed <= CNT_W'(HI));
    end
  endgenerate

  always_comb begin
    winCode = '0;
    for (int i = NUM_RATES - 1; i >= 0; i--) begin
      if (inWin[i]) winCode = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      refCnt   <= '0;
      perCnt   <= '0;
      measDone <= 1'b0;
      measCode <= '0;
    end else begin
      measDone <= 1'b0;
      if (strb.restartMeas) begin
        armed  <= 1'b0;
        refCnt <= '0;
        perCnt <= '0;
      end else if (lrRise) begin
        if (!armed) begin
          armed  <= 1'b1;
          refCnt <= '0;
          perCnt <= '0;
        end else if (perCnt == PER_W'(WIN_PERIODS - 1)) begin
          refCnt   <= '0;
          perCnt   <= '0;
          measDone <= 1'b1;
          measCode <= winCode;
        end else begin
          perCnt <= perCnt + 1'b1;
          refCnt <= refCnt + 1'b1;
        end
      end else if (refCnt >= CNT_W'(MAX_HI)) begin
        // too slow or stopped: report no rate and re-arm
        armed    <= 1'b0;
        refCnt   <= '0;
        perCnt   <= '0;
        measDone <= 1'b1;
        measCode <= '0;
      end else begin
        refCnt <= refCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqCode <= '0;
    end else if (strb.clrReq) begin
      reqCode <= '0;
    end else if (strb.loadReq) begin
      reqCode <= measCode;
    end
  end

  logic [FLASH_W-1:0] flashCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flashCnt <= '0;
    else       flashCnt <= flashCnt + 1'b1;
  end

  assign flashBit = flashCnt[FLASH_W-1];

  always_comb begin
    famSel   = 1'b0;
    mclkMult = 2'd0;
    case (reqCode)
      3'd1: begin famSel = 1'b0; mclkMult = 2'd2; end
      3'd2: begin famSel = 1'b1; mclkMult = 2'd2; end
      3'd3: begin famSel = 1'b0; mclkMult = 2'd1; end
      3'd4: begin famSel = 1'b1; mclkMult = 2'd1; end
      3'd5: begin famSel = 1'b0; mclkMult = 2'd0; end
      3'd6: begin famSel = 1'b1; mclkMult = 2'd0; end
      default: begin famSel = 1'b0; mclkMult = 2'd0; end
    endcase
  end

endmodule

// File: rtl/rate_seq_ctrl.sv
module rate_seq_ctrl
  import rate_det_pkg::*;
#(
  parameter int QUAL_COUNT  = 3,
  parameter int SETTLE_WIN  = 4,
  parameter int ACK_TIMEOUT = 24576000,
  parameter int RETRY_GAP   = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              measDone,
  input  logic [CODE_W-1:0] measCode,
  input  logic [CODE_W-1:0] reqCode,
  input  logic              ackRise,
  input  logic              flashBit,
  output ctrlStrb_t         strb,
  output logic              irqN,
  output logic              muteOut,
  output logic              fifoEmptyOut,
  output logic              lockLed,
  output logic              errorOut
);

  localparam int TMR_MAX = (ACK_TIMEOUT > RETRY_GAP) ? ACK_TIMEOUT : RETRY_GAP;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int SET_W   = $clog2(SETTLE_WIN + 1);
  localparam int AGR_W   = $clog2(QUAL_COUNT + 1);

  seqState_t         state, nxtState;
  logic [CODE_W-1:0] cand;
  logic [AGR_W-1:0]  agree, nextAgree;
  logic              qualNow;
  logic [TMR_W-1:0]  timer;
  logic [SET_W-1:0]  settleCnt;
  logic              retried;

  // qualification: consecutive identical measurement codes
  always_comb begin
    if (measCode == cand)
      nextAgree = (agree == AGR_W'(QUAL_COUNT)) ? agree : agree + 1'b1;
    else
      nextAgree = AGR_W'(1);
  end

  assign qualNow = measDone && (nextAgree == AGR_W'(QUAL_COUNT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cand  <= '0;
      agree <= '0;
    end else if (measDone) begin
      cand  <= measCode;
      agree <= nextAgree;
    end
  end

  always_comb begin
    nxtState = state;
    strb     = '0;
    case (state)
      ST_HUNT: begin
        if (qualNow && measCode != '0) begin
          nxtState     = ST_REQ;
          strb.loadReq = 1'b1;
        end
      end
      ST_REQ: begin
        if (ackRise) begin
          nxtState         = ST_SETTLE;
          strb.restartMeas = 1'b1;
        end else if (timer == TMR_W'(ACK_TIMEOUT - 1)) begin
          nxtState = retried ? ST_ERR : ST_GAP;
        end
      end
      ST_GAP: begin
        if (timer == TMR_W'(RETRY_GAP - 1)) nxtState = ST_REQ;
      end
      ST_SETTLE: begin
        if (measDone && settleCnt == SET_W'(SETTLE_WIN - 1)) begin
          if (measCode == reqCode) begin
            nxtState = ST_LOCK;
          end else begin
            nxtState    = ST_HUNT;
            strb.clrReq = 1'b1;
          end
        end
      end
      ST_LOCK, ST_ERR: begin
        if (qualNow && measCode != reqCode) begin
          if (measCode == '0) begin
            nxtState    = ST_HUNT;
            strb.clrReq = 1'b1;
          end else begin
            nxtState     = ST_REQ;
            strb.loadReq = 1'b1;
          end
        end
      end
      default: nxtState = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HUNT;
      timer     <= '0;
      settleCnt <= '0;
      retried   <= 1'b0;
    end else begin
      state <= nxtState;

      if (nxtState != state)
        timer <= '0;
      else if (state == ST_REQ || state == ST_GAP)
        timer <= timer + 1'b1;

      if (state != ST_SETTLE)
        settleCnt <= '0;
      else if (measDone)
        settleCnt <= settleCnt + 1'b1;

      if (nxtState == ST_GAP)
        retried <= 1'b1;
      else if (nxtState == ST_REQ && state != ST_REQ && state != ST_GAP)
        retried <= 1'b0;
    end
  end

  logic pending;
  assign pending = (state == ST_REQ) || (state == ST_GAP) ||
                   (state == ST_SETTLE) || (state == ST_ERR);

  assign irqN         = (state != ST_REQ);
  assign muteOut      = (state != ST_LOCK);
  assign fifoEmptyOut = pending;
  assign lockLed      = (state == ST_LOCK) | (pending & flashBit);
  assign errorOut     = (state == ST_ERR);

endmodule

// File: rtl/i2s_rate_switch.sv
module i2s_rate_switch
  import rate_det_pkg::*;
#(
  parameter int REF_KHZ     = 24576,
  parameter int WIN_PERIODS = 64,
  parameter int QUAL_COUNT  = 3,
  parameter int SETTLE_WIN  = 4,
  parameter int ACK_TIMEOUT = 24576000,
  parameter int RETRY_GAP   = 2048,
  parameter int FLASH_W     = 22
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lrclkIn,
  input  logic       ackIn,
  output logic       irqN,
  output logic       muteOut,
  output logic       fifoEmptyOut,
  output logic       lockLed,
  output logic       errorOut,
  output logic [2:0] rateCode,
  output logic       famSel,
  output logic [1:0] mclkMult
);

  ctrlStrb_t         strb;
  logic              measDone;
  logic [CODE_W-1:0] measCode;
  logic [CODE_W-1:0] reqCode;
  logic              ackRise;
  logic              flashBit;

  rate_meas_path #(
    .REF_KHZ    (REF_KHZ),
    .WIN_PERIODS(WIN_PERIODS),
    .FLASH_W    (FLASH_W)
  ) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .lrclkIn (lrclkIn),
    .ackIn   (ackIn),
    .strb    (strb),
    .measDone(measDone),
    .measCode(measCode),
    .reqCode (reqCode),
    .ackRise (ackRise),
    .flashBit(flashBit),
    .famSel  (famSel),
    .mclkMult(mclkMult)
  );

  rate_seq_ctrl #(
    .QUAL_COUNT (QUAL_COUNT),
    .SETTLE_WIN (SETTLE_WIN),
    .ACK_TIMEOUT(ACK_TIMEOUT),
    .RETRY_GAP  (RETRY_GAP)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .measDone    (measDone),
    .measCode    (measCode),
    .reqCode     (reqCode),
    .ackRise     (ackRise),
    .flashBit    (flashBit),
    .strb        (strb),
    .irqN        (irqN),
    .muteOut     (muteOut),
    .fifoEmptyOut(fifoEmptyOut),
    .lockLed     (lockLed),
    .errorOut    (errorOut)
  );

  assign rateCode = reqCode;

endmodule

// File: rtl/i2s_rate_switch_chk.sv
module i2s_rate_switch_chk (
  input logic       clk,
  input logic       rstN,
  input logic       irqN,
  input logic       muteOut,
  input logic       fifoEmptyOut,
  input logic       lockLed,
  input logic       errorOut,
  input logic [2:0] rateCode
);

  // R5: an outstanding request always comes with mute and a forced-empty buffer
  a_r5_irq_mutes: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (muteOut && fifoEmptyOut));

  // R5: the interrupt only falls with a valid rate published
  a_r5_fall_has_rate: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> (rateCode != 3'd0));

  // R7: audio passes only in the confirmed, quiet state
  a_r7_unmute_locked: assert property (@(posedge clk) disable iff (!rstN)
    !muteOut |-> (irqN && lockLed && rateCode != 3'd0 && !fifoEmptyOut && !errorOut));

  // R8: error state keeps the line released and the output muted
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    errorOut |-> (irqN && muteOut));

  // R1: only seven code values exist
  a_r1_code_range: assert property (@(posedge clk) disable iff (!rstN)
    rateCode <= 3'd6);

  // R9: with no rate selected nothing is requested and the output is silent
  a_r9_zero_muted: assert property (@(posedge clk) disable iff (!rstN)
    (rateCode == 3'd0) |-> (muteOut && irqN));

endmodule

bind i2s_rate_switch i2s_rate_switch_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .irqN        (irqN),
  .muteOut     (muteOut),
  .fifoEmptyOut(fifoEmptyOut),
  .lockLed     (lockLed),
  .errorOut    (errorOut),
  .rateCode    (rateCode)
);

// File: tb/i2s_rate_switch_tb_top.sv
`timescale 1ns/1ps
module i2s_rate_switch_tb_top;

  localparam int ACK_TO = 3000;
  localparam int GAP    = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lrclkIn = 1'b0;
  logic       ackIn = 1'b0;
  logic       irqN, muteOut, fifoEmptyOut, lockLed, errorOut, famSel;
  logic [2:0] rateCode;
  logic [1:0] mclkMult;

  int  total = 0;
  int  fails = 0;
  int  cyc = 0;
  int  halfPer = 0;
  bit  glitchReq = 1'b0;
  int  irqFalls = 0;
  int  muteLowCnt = 0;
  logic irqPrev = 1'b1;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  i2s_rate_switch #(
    .REF_KHZ    (19200),
    .WIN_PERIODS(2),
    .QUAL_COUNT (3),
    .SETTLE_WIN (2),
    .ACK_TIMEOUT(ACK_TO),
    .RETRY_GAP  (GAP),
    .FLASH_W    (4)
  ) dut_i (
    .clk(clk), .rstN(rstN), .lrclkIn(lrclkIn), .ackIn(ackIn),
    .irqN(irqN), .muteOut(muteOut), .fifoEmptyOut(fifoEmptyOut),
    .lockLed(lockLed), .errorOut(errorOut), .rateCode(rateCode),
    .famSel(famSel), .mclkMult(mclkMult)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    irqPrev <= irqN;
    if (rstN && irqPrev && !irqN) irqFalls <= irqFalls + 1;
    if (rstN && !muteOut) muteLowCnt <= muteLowCnt + 1;
  end

  // LRCLK generator; halfPer 0 holds the line low
  initial begin
    forever begin
      if (halfPer == 0) begin
        lrclkIn = 1'b0;
        @(negedge clk);
      end else begin
        repeat (halfPer) @(negedge clk);
        lrclkIn = ~lrclkIn;
        if (lrclkIn && glitchReq) begin
          glitchReq = 1'b0;
          repeat (halfPer / 2) @(negedge clk);
          lrclkIn = 1'b0;
          repeat (4) @(negedge clk);
          lrclkIn = 1'b1;
          repeat (halfPer - halfPer / 2 - 4) @(negedge clk);
          lrclkIn = 1'b0;
        end
      end
    end
  end

  function automatic int halfFor(input int code);
    case (code)
      1: return 218;
      2: return 200;
      3: return 109;
      4: return 100;
      5: return 54;
      default: return 50;
    endcase
  endfunction

  function automatic int famFor(input int code);
    return (code == 2 || code == 4 || code == 6) ? 1 : 0;
  endfunction

  function automatic int multFor(input int code);
    return (code <= 2) ? 2 : ((code <= 4) ? 1 : 0);
  endfunction

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitIrq(input logic lvl, input int limit, output int waited);
    waited = 0;
    while (irqN !== lvl && waited < limit) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic waitMute(input logic lvl, input int limit, output int waited);
    waited = 0;
    while (muteOut !== lvl && waited < limit) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic pulseAck();
    @(negedge clk);
    ackIn = 1'b1;
    repeat (4) @(negedge clk);
    ackIn = 1'b0;
  endtask

  task automatic sampleFlash(input string req);
    int ones = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (lockLed) ones++;
    end
    chkEq(req, "lockLed toggles while pending", int'(ones > 0 && ones < 64), 1);
  endtask

  task automatic requestAndLock(input int code);
    int w;
    halfPer = halfFor(code);
    waitIrq(1'b0, 8000, w);
    chkEq("R5", "irqN low on new rate", int'(irqN), 0);
    chkEq("R1", "rateCode", int'(rateCode), code);
    chkEq("R2", "famSel", int'(famSel), famFor(code));
    chkEq("R3", "mclkMult", int'(mclkMult), multFor(code));
    pulseAck();
    waitMute(1'b0, 8000, w);
    chkEq("R7", "unmuted after ack and settle", int'(muteOut), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chkEq("R10", "irqN in reset", int'(irqN), 1);
    chkEq("R10", "muteOut in reset", int'(muteOut), 1);
    chkEq("R10", "lockLed in reset", int'(lockLed), 0);
    chkEq("R10", "rateCode in reset", int'(rateCode), 0);
    chkEq("R10", "errorOut in reset", int'(errorOut), 0);
    rstN = 1'b1;
    repeat (2000) @(negedge clk);
    chkEq("R9", "no request without LRCLK", irqFalls, 0);
    chkEq("R10", "still muted without LRCLK", int'(muteOut), 1);
  endtask

  task automatic t_first_lock();
    int t0, w, ones;
    t0 = cyc;
    halfPer = 200;
    waitIrq(1'b0, 8000, w);
    // first rise after 200 cycles, then three 800-cycle windows
    chkEq("R4", "request needs three windows", int'((cyc - t0) >= 2600 && (cyc - t0) <= 3500), 1);
    chkEq("R5", "mute with request", int'(muteOut), 1);
    chkEq("R5", "empty with request", int'(fifoEmptyOut), 1);
    chkEq("R10", "first rate code", int'(rateCode), 2);
    chkEq("R2", "famSel 48k", int'(famSel), 1);
    chkEq("R3", "mclkMult 48k", int'(mclkMult), 2);
    sampleFlash("R6");
    chkEq("R6", "empty while pending", int'(fifoEmptyOut), 1);
    pulseAck();
    repeat (6) @(negedge clk);
    chkEq("R7", "irqN released by ack", int'(irqN), 1);
    chkEq("R7", "still muted during settle", int'(muteOut), 1);
    waitMute(1'b0, 8000, w);
    chkEq("R7", "unmuted after settle", int'(muteOut), 0);
    chkEq("R7", "empty cleared", int'(fifoEmptyOut), 0);
    ones = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (lockLed) ones++;
    end
    chkEq("R7", "lockLed steady", ones, 64);
  endtask

  task automatic t_glitch();
    int f0, m0;
    f0 = irqFalls;
    m0 = muteLowCnt;
    glitchReq = 1'b1;
    repeat (5000) @(negedge clk);
    chkEq("R4", "glitch raises no request", irqFalls - f0, 0);
    chkEq("R4", "stays unmuted across glitch", muteLowCnt - m0, 5000);
    chkEq("R4", "rate kept across glitch", int'(rateCode), 2);
  endtask

  task automatic t_all_rates();
    requestAndLock(1);
    requestAndLock(3);
    requestAndLock(4);
    requestAndLock(5);
    requestAndLock(6);
  endtask

  task automatic t_settle_mismatch();
    int w, m0;
    halfPer = halfFor(1);
    waitIrq(1'b0, 8000, w);
    chkEq("R1", "rateCode 44.1k", int'(rateCode), 1);
    m0 = muteLowCnt;
    halfPer = halfFor(4);
    pulseAck();
    w = 0;
    while (!(rateCode == 3'd4 && irqN == 1'b0) && w < 8000) begin
      @(negedge clk);
      w++;
    end
    chkEq("R7", "re-request after settle mismatch", int'(rateCode), 4);
    chkEq("R7", "no unmute on mismatch", muteLowCnt - m0, 0);
    pulseAck();
    waitMute(1'b0, 8000, w);
    chkEq("R7", "lock after second request", int'(muteOut), 0);
  endtask

  task automatic t_invalid();
    int w, f0;
    f0 = irqFalls;
    halfPer = 150;
    waitMute(1'b1, 6000, w);
    repeat (2000) @(negedge clk);
    chkEq("R9", "muted on no rate", int'(muteOut), 1);
    chkEq("R9", "lock cleared", int'(lockLed), 0);
    chkEq("R9", "rateCode zero", int'(rateCode), 0);
    chkEq("R9", "no interrupt", irqFalls - f0, 0);
    chkEq("R9", "empty not forced", int'(fifoEmptyOut), 0);
  endtask

  task automatic t_timeout();
    int w, t0;
    halfPer = halfFor(4);
    waitIrq(1'b0, 8000, w);
    t0 = cyc;
    waitIrq(1'b1, ACK_TO + 100, w);
    chkEq("R8", "first timeout length", int'((cyc - t0) >= ACK_TO - 5 && (cyc - t0) <= ACK_TO + 5), 1);
    chkEq("R8", "muted in gap", int'(muteOut), 1);
    waitIrq(1'b0, GAP + 20, w);
    chkEq("R8", "interrupt re-asserted", int'(irqN), 0);
    chkEq("R8", "no error yet", int'(errorOut), 0);
    waitIrq(1'b1, ACK_TO + 100, w);
    repeat (3) @(negedge clk);
    chkEq("R8", "error after second timeout", int'(errorOut), 1);
    chkEq("R8", "irqN high in error", int'(irqN), 1);
    repeat (200) @(negedge clk);
    chkEq("R8", "no third request", int'(irqN), 1);
    chkEq("R8", "muted in error", int'(muteOut), 1);
    halfPer = halfFor(2);
    waitIrq(1'b0, 8000, w);
    chkEq("R8", "error cleared by new rate", int'(errorOut), 0);
    chkEq("R8", "new request code", int'(rateCode), 2);
    pulseAck();
    waitMute(1'b0, 8000, w);
    chkEq("R8", "locks after recovery", int'(muteOut), 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
    finishRun();
  end

  initial begin
    t_reset();
    t_first_lock();
    t_glitch();
    t_all_rates();
    t_settle_mismatch();
    t_invalid();
    t_timeout();
    finishRun();
  end

endmodule